// File: doc/BRIEF.md
# Zero-Crossing Supervisor with Sequence Check

This block supervises the ascending zero-crossing strobes of a three-phase voltage front end. A separate detector produces one single-cycle strobe per phase whenever that phase's voltage rises through zero. A scan-frame tick marks the analog scan period. The supervisor counts frame ticks since the most recent crossing on any phase. If that count reaches a programmable limit, it raises a sticky "line idle" flag.

It also follows the order in which the phases cross. In a healthy system each crossing is followed by the next phase in the rotation A, B, C, A. Once every phase has crossed at least once since reset, any crossing that skips a phase or runs backwards raises a sticky "rotation fault" flag. So do two or more crossings arriving in the same cycle.

Each flag stays set until the host pulses its clear input. Each flag is gated by its own mask bit onto one shared active-low interrupt line. The block is meant to sit next to a crossing detector and a register file. The register file supplies the limit, the masks and the clear strobes, and it reads back the flags.

Top module: `zc_supervisor`

## Requirements
- R1: While reset is high and in the first cycle after it, both flags are 0 and `irq_n` is 1.
- R2: With a limit L of 1 or more, `idle_flag` becomes 1 after the L-th consecutive frame tick that has no crossing strobe in the same cycle. Ticks 1 to L-1 leave it at 0.
- R3: A crossing strobe on any phase restarts the frame count from zero, including when it arrives in the same cycle as a frame tick. The strobe bits are bit 0 for A, bit 1 for B and bit 2 for C.
- R4: A limit of 0 disables idle detection. After the limit is reached, the count restarts, so a further L quiet ticks are needed before the limit is reached again.
- R5: Once armed, a single crossing sets `seq_flag` when its phase is neither the previous phase nor the successor of the previous phase in the rotation A→B→C→A. A crossing that repeats the previous phase is not a fault.
- R6: The order check is disarmed until each of the three phases has crossed at least once since reset.
- R7: When armed, strobes on two or more phases in one cycle set `seq_flag`. The first crossing after such a cycle is not compared with any previous phase.
- R8: Both flags are sticky and are cleared by a one-cycle host clear strobe. A set event in the same cycle as a clear leaves the flag at 1.
- R9: `irq_n` is 0 exactly when (`idle_flag` and `mask_idle`) or (`seq_flag` and `mask_seq`) holds, and it follows the masks without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_strobe | input | 3 | Ascending-crossing strobes: bit 0 A, bit 1 B, bit 2 C |
| frame_tick | input | 1 | One pulse per analog scan frame |
| idle_limit | input | CNT_W | Quiet frames before idle flag; 0 disables |
| mask_idle | input | 1 | Enables idle flag onto the interrupt |
| mask_seq | input | 1 | Enables rotation fault flag onto the interrupt |
| clr_idle | input | 1 | Host clear strobe for idle flag |
| clr_seq | input | 1 | Host clear strobe for rotation fault flag |
| idle_flag | output | 1 | Sticky no-crossing flag |
| seq_flag | output | 1 | Sticky rotation fault flag |
| irq_n | output | 1 | Active-low shared interrupt |

## Verification
The order check is swept over all nine pairs of previous and current phase after arming. This separates correct rotation, repeats, skips and reversals. Further patterns cover crossings before arming and simultaneous strobes, which separate the arming rule and the reset of the previous phase from plain pair comparison. The idle timeout is swept over limits 1 to 5, where each limit is checked at one tick before expiry and at expiry, and again after a clear to show the restart. Crossings inserted alone and together with a tick show that both restart the count. A zero limit shows the disable. The four mask combinations with both flags set separate the two interrupt gates.

// File: rtl/zcs_pkg.sv
package zcs_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_A    = 2'd1,
        PH_B    = 2'd2,
        PH_C    = 2'd3
    } phase_t;

    localparam int NUM_PH = 3;

    // successor in the rotation A -> B -> C -> A
    function automatic phase_t ph_next(input phase_t p);
        case (p)
            PH_A:    return PH_B;
            PH_B:    return PH_C;
            PH_C:    return PH_A;
            default: return PH_NONE;
        endcase
    endfunction

    // single strobe to phase code
    function automatic phase_t ph_decode(input logic [NUM_PH-1:0] s);
        case (s)
            3'b001:  return PH_A;
            3'b010:  return PH_B;
            3'b100:  return PH_C;
            default: return PH_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic any;
        logic multi;
        phase_t ph;
    } xing_t;

endpackage

// File: rtl/zcs_timeout.sv
module zcs_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             crossing,
    input  logic             frame_tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_inc;
    logic             reach;

    assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    assign reach   = cnt_inc >= {1'b0, limit};
    assign expire  = !crossing && frame_tick && (limit != '0) && reach;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (crossing) begin
            cnt_q <= '0;
        end else if (frame_tick && limit != '0) begin
            if (reach) cnt_q <= '0;
            else       cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/zcs_order.sv
module zcs_order
    import zcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] strobe,
    output logic              fault
);
    xing_t             x;
    phase_t            last_q;
    logic [NUM_PH-1:0] seen_q;
    logic              armed;
    logic              bad_step;

    always_comb begin
        x.any   = |strobe;
        x.multi = (strobe & (strobe - NUM_PH'(1))) != '0;
        x.ph    = ph_decode(strobe);
    end

    assign armed    = &seen_q;
    assign bad_step = (last_q != PH_NONE) && (x.ph != last_q) && (x.ph != ph_next(last_q));
    assign fault    = armed && x.any && (x.multi || bad_step);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            last_q <= PH_NONE;
        end else if (x.any) begin
            seen_q <= seen_q | strobe;
            last_q <= x.multi ? PH_NONE : x.ph;
        end
    end
endmodule

// File: rtl/zcs_flag.sv
module zcs_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/zc_supervisor.sv
module zc_supervisor
    import zcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       zc_strobe,
    input  logic             frame_tick,
    input  logic [CNT_W-1:0] idle_limit,
    input  logic             mask_idle,
    input  logic             mask_seq,
    input  logic             clr_idle,
    input  logic             clr_seq,
    output logic             idle_flag,
    output logic             seq_flag,
    output logic             irq_n
);
    localparam int NFLAG = 2;

    logic             expire;
    logic             fault;
    logic [NFLAG-1:0] set_v, clr_v, flag_v, mask_v;

    zcs_timeout #(.CNT_W(CNT_W)) u_timeout (
        .clk        (clk),
        .rst        (rst),
        .crossing   (|zc_strobe),
        .frame_tick (frame_tick),
        .limit      (idle_limit),
        .expire     (expire)
    );

    zcs_order u_order (
        .clk    (clk),
        .rst    (rst),
        .strobe (zc_strobe),
        .fault  (fault)
    );

    assign set_v  = {fault, expire};
    assign clr_v  = {clr_seq, clr_idle};
    assign mask_v = {mask_seq, mask_idle};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        zcs_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (set_v[i]),
            .clr  (clr_v[i]),
            .flag (flag_v[i])
        );
    end

    assign idle_flag = flag_v[0];
    assign seq_flag  = flag_v[1];
    assign irq_n     = ~|(flag_v & mask_v);
endmodule

// File: rtl/zcs_chk.sv
module zcs_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       zc_strobe,
    input logic             frame_tick,
    input logic [CNT_W-1:0] idle_limit,
    input logic             mask_idle,
    input logic             mask_seq,
    input logic             clr_idle,
    input logic             clr_seq,
    input logic             idle_flag,
    input logic             seq_flag,
    input logic             irq_n
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!idle_flag && !seq_flag && irq_n));

    // R2
    idle_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(frame_tick && zc_strobe == 3'b000));

    // R4
    idle_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(idle_limit != '0));

    // R5
    seq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_flag) |-> $past(zc_strobe != 3'b000));

    // R8
    idle_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && !clr_idle) |=> idle_flag);

    // R8
    seq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_flag && !clr_seq) |=> seq_flag);

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_idle && !frame_tick) |=> !idle_flag);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && mask_idle) |-> !irq_n);

    // R9
    irq_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_flag && mask_seq) |-> !irq_n);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!(idle_flag && mask_idle) && !(seq_flag && mask_seq)) |-> irq_n);
endmodule

bind zc_supervisor zcs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .zc_strobe  (zc_strobe),
    .frame_tick (frame_tick),
    .idle_limit (idle_limit),
    .mask_idle  (mask_idle),
    .mask_seq   (mask_seq),
    .clr_idle   (clr_idle),
    .clr_seq    (clr_seq),
    .idle_flag  (idle_flag),
    .seq_flag   (seq_flag),
    .irq_n      (irq_n)
);

// File: tb/tb_zc_supervisor.sv
module tb_zc_supervisor;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       zc_strobe = '0;
    logic             frame_tick = 1'b0;
    logic [CNT_W-1:0] idle_limit = '0;
    logic             mask_idle = 1'b0;
    logic             mask_seq = 1'b0;
    logic             clr_idle = 1'b0;
    logic             clr_seq = 1'b0;
    logic             idle_flag, seq_flag, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zc_supervisor #(.CNT_W(CNT_W)) dut (.*);

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive for one edge, then sample 1 ns after it
    task automatic step(input logic [2:0] z, input logic ft, input logic ci, input logic cs);
        zc_strobe = z; frame_tick = ft; clr_idle = ci; clr_seq = cs;
        @(posedge clk); #1;
        zc_strobe = '0; frame_tick = 1'b0; clr_idle = 1'b0; clr_seq = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    function automatic logic [2:0] sb(input int p);
        return 3'(1 << p);
    endfunction

    initial begin
        // R1
        do_reset();
        check("R1 idle", idle_flag, 1'b0);
        check("R1 seq", seq_flag, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);

        // R5: all nine previous/current pairs once armed
        for (int prev = 0; prev < 3; prev++) begin
            for (int cur = 0; cur < 3; cur++) begin
                do_reset();
                step(sb(0), 0, 0, 0); step(sb(1), 0, 0, 0); step(sb(2), 0, 0, 0);
                for (int k = 0; k <= prev; k++) begin
                    if (prev != 2) step(sb(k), 0, 0, 0);
                end
                check("R5 no fault on correct lap", seq_flag, 1'b0);
                step(sb(cur), 0, 0, 0);
                check($sformatf("R5 pair %0d->%0d", prev, cur), seq_flag,
                      (cur != prev) && (cur != (prev + 1) % 3));
            end
        end

        // R6: out of order before arming is ignored
        do_reset();
        step(sb(0), 0, 0, 0); step(sb(2), 0, 0, 0);
        check("R6 A->C before armed", seq_flag, 1'b0);
        step(sb(1), 0, 0, 0);
        check("R6 C->B before armed", seq_flag, 1'b0);
        step(sb(0), 0, 0, 0);
        check("R6 B->A once armed", seq_flag, 1'b1);

        // R7: simultaneous strobes, then no compare
        do_reset();
        step(sb(0), 0, 0, 0); step(sb(1), 0, 0, 0); step(sb(2), 0, 0, 0);
        step(3'b011, 0, 0, 0);
        check("R7 simultaneous strobes", seq_flag, 1'b1);
        step(3'b000, 0, 0, 1);
        check("R8 seq clear", seq_flag, 1'b0);
        step(sb(2), 0, 0, 0);
        check("R7 first crossing after multi", seq_flag, 1'b0);

        // R8: set beats clear
        do_reset();
        step(sb(0), 0, 0, 0); step(sb(1), 0, 0, 0); step(sb(2), 0, 0, 0);
        step(sb(1), 0, 0, 1);
        check("R8 set with clear", seq_flag, 1'b1);

        // R2 and R4: limits 1..5, expiry and restart
        for (int lim = 1; lim <= 5; lim++) begin
            do_reset();
            idle_limit = CNT_W'(lim);
            for (int k = 1; k < lim; k++) step(3'b000, 1, 0, 0);
            check($sformatf("R2 L=%0d before expiry", lim), idle_flag, 1'b0);
            step(3'b000, 1, 0, 0);
            check($sformatf("R2 L=%0d at expiry", lim), idle_flag, 1'b1);
            step(3'b000, 0, 1, 0);
            check("R8 idle clear", idle_flag, 1'b0);
            for (int k = 1; k < lim; k++) step(3'b000, 1, 0, 0);
            check($sformatf("R4 L=%0d restart before", lim), idle_flag, 1'b0);
            step(3'b000, 1, 0, 0);
            check($sformatf("R4 L=%0d restart at", lim), idle_flag, 1'b1);
        end

        // R3: crossing alone, then crossing with tick
        for (int ph = 0; ph < 3; ph++) begin
            do_reset();
            idle_limit = CNT_W'(3);
            step(3'b000, 1, 0, 0); step(3'b000, 1, 0, 0);
            step(sb(ph), 0, 0, 0);
            step(3'b000, 1, 0, 0); step(3'b000, 1, 0, 0);
            check($sformatf("R3 crossing %0d restarts", ph), idle_flag, 1'b0);
            step(sb(ph), 1, 0, 0);
            step(3'b000, 1, 0, 0); step(3'b000, 1, 0, 0);
            check($sformatf("R3 crossing %0d with tick", ph), idle_flag, 1'b0);
            step(3'b000, 1, 0, 0);
            check($sformatf("R3 expiry after %0d", ph), idle_flag, 1'b1);
        end

        // R4: zero limit disables
        do_reset();
        idle_limit = '0;
        for (int k = 0; k < 12; k++) step(3'b000, 1, 0, 0);
        check("R4 zero limit", idle_flag, 1'b0);

        // R9: both flags set, sweep masks
        do_reset();
        idle_limit = CNT_W'(1);
        step(sb(0), 0, 0, 0); step(sb(1), 0, 0, 0); step(sb(2), 0, 0, 0);
        step(sb(1), 0, 0, 0);
        step(3'b000, 1, 0, 0);
        for (int m = 0; m < 4; m++) begin
            mask_idle = m[0]; mask_seq = m[1];
            #1;
            check($sformatf("R9 masks %0d both set", m), irq_n, !(m[0] || m[1]));
        end
        step(3'b000, 0, 1, 0);
        for (int m = 0; m < 4; m++) begin
            mask_idle = m[0]; mask_seq = m[1];
            #1;
            check($sformatf("R9 masks %0d seq only", m), irq_n, !m[1]);
        end
        mask_idle = 1'b0; mask_seq = 1'b0;

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule